// File: doc/BRIEF.md
# Masked Reference Compare Engine

This block checks each acquired state row against a stored reference image, one bit at a time. A channel mask picks the bits that take part, and a row window picks the rows. Each compared row gives a difference vector and a mismatch flag. When an acquisition ends, the block issues a verdict that gives the number of mismatching rows and whether the whole capture was equal to the reference.

Software or a sequencer loads the reference through a small host write port. That port can write a full row, change a single bit of a row, or load the mask. The reference can also be filled by streaming an acquisition in copy mode, which stores each row at its index and compares nothing. Acquisition memory is shared with the reference image, so the image holds `ACQ_DEPTH/2` rows, which is half the capture depth. A stop mode tells the block whether to request a halt of repeated runs on an equal verdict or on an unequal one.

Top module: `ref_compare_top`

## Requirements
- R1: During reset and in the cycle after reset, `diff_valid`, `diff_bits`, `row_mismatch`, `verdict_valid`, `verdict_equal`, `mismatch_count` and `stop_req` are all zero. The mask comes out of reset with every channel enabled (all ones).
- R2: A host write with `host_op`=0 stores `host_data` as reference row `host_row`. With `host_op`=1 it sets only bit `host_bit` of row `host_row` to `host_data[0]`. With `host_op`=2 it loads the mask from `host_data`. Code 3 does nothing.
- R3: A row taken with `row_valid` and `copy_en` both high is written into reference row `row_idx`. It produces no difference output and no verdict.
- R4: A row taken at clock edge k with `copy_en` low and an index inside the window appears at edge k+1 as `diff_valid`=1, with `diff_row`=`row_idx` and `diff_bits`=(`row_data` XOR reference row) AND mask. Mask and window are sampled at edge k.
- R5: A bit whose mask bit is 0 never shows as a difference.
- R6: A row is compared only when `win_lo` <= `row_idx` <= `win_hi`. Rows outside the window give no difference output and are not counted.
- R7: `row_mismatch` is high exactly when `diff_valid` is high and `diff_bits` is non-zero.
- R8: When a compare-mode row with `row_last` high is taken at edge k, `verdict_valid` pulses for one cycle at edge k+2. At that point `mismatch_count` holds the number of mismatching in-window rows since the previous verdict, including that last row, and `verdict_equal` is 1 exactly when that count is 0. `mismatch_count` holds its value until the next verdict.
- R9: `stop_req` pulses together with `verdict_valid`. With `stop_mode`=0 it pulses when the verdict is equal; with `stop_mode`=1 it pulses when the verdict is unequal. The mode is sampled with the last row.
- R10: If `win_lo` > `win_hi`, no row is compared, and the verdict is equal with a count of 0 whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host write strobe |
| host_op | input | 2 | 0 row write, 1 bit edit, 2 mask load, 3 no operation |
| host_row | input | 5 | Reference row addressed by the host |
| host_bit | input | 4 | Bit position for a bit edit |
| host_data | input | 16 | Row data, mask value, or new bit value in bit 0 |
| copy_en | input | 1 | Streamed rows load the reference instead of being compared |
| stop_mode | input | 1 | 0 stop on equal, 1 stop on unequal |
| win_lo | input | 5 | First row of the compare window |
| win_hi | input | 5 | Last row of the compare window |
| row_valid | input | 1 | Acquired row present |
| row_last | input | 1 | Row closes the acquisition |
| row_idx | input | 5 | Index of the acquired row |
| row_data | input | 16 | Acquired state word |
| diff_valid | output | 1 | Difference result present |
| diff_row | output | 5 | Row index of the result |
| diff_bits | output | 16 | Bits that differ under the mask |
| row_mismatch | output | 1 | The result row differs |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict_equal | output | 1 | Whole acquisition matched |
| mismatch_count | output | 6 | Mismatching rows in the last acquisition |
| stop_req | output | 1 | Request to halt repeated runs |

## Verification
The bench attacks the one-cycle read latency of the reference. A compare aligned to the wrong stage would check a row against its neighbour's reference, and a row whose reference was just copied or bit-edited would then show false differences. It narrows the window to a single row and also inverts it to make it empty: an off-by-one bound would count a row outside the window, and an empty window must still give an equal verdict from a last row that lies outside it. It runs a capture with the reset mask, a partial mask and single-bit edits, so a mask applied to the wrong operand, or a missing one, shows as extra difference bits. It runs both stop modes with equal and with unequal data, so an inverted mode, or a count not cleared between acquisitions, shows up in the verdict.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;

    typedef enum logic [1:0] {
        HOP_ROW  = 2'd0,
        HOP_BIT  = 2'd1,
        HOP_MASK = 2'd2,
        HOP_IDLE = 2'd3
    } host_op_e;

    typedef enum logic {
        STOP_ON_EQUAL = 1'b0,
        STOP_ON_DIFF  = 1'b1
    } stop_mode_e;

    // control carried alongside a row through the first pipeline stage
    typedef struct packed {
        logic       cmp;
        logic       fin;
        stop_mode_e mode;
    } stage_ctl_t;

    function automatic logic row_in_window(input int unsigned idx,
                                           input int unsigned lo,
                                           input int unsigned hi);
        return (idx >= lo) && (idx <= hi);
    endfunction

    function automatic logic stop_wanted(input stop_mode_e m, input logic equal);
        return (m == STOP_ON_EQUAL) ? equal : !equal;
    endfunction

endpackage

// File: rtl/refcmp_image.sv
module refcmp_image
    import refcmp_pkg::*;
#(
    parameter  int WIDTH = 16,
    parameter  int ROWS  = 32,
    localparam int AW    = $clog2(ROWS),
    localparam int BW    = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_en,
    input  host_op_e         host_op,
    input  logic [AW-1:0]    host_row,
    input  logic [BW-1:0]    host_bit,
    input  logic [WIDTH-1:0] host_data,
    input  logic             cp_en,
    input  logic [AW-1:0]    cp_row,
    input  logic [WIDTH-1:0] cp_data,
    input  logic [AW-1:0]    rd_row,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] mask
);

    logic [WIDTH-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else if (host_en && host_op == HOP_MASK) begin
            mask <= host_data;
        end
    end

    // the host port is applied after the copy path, so it wins on a shared row
    always_ff @(posedge clk) begin
        if (cp_en && !rst) begin
            mem[cp_row] <= cp_data;
        end
        if (host_en && !rst) begin
            case (host_op)
                HOP_ROW: mem[host_row]           <= host_data;
                HOP_BIT: mem[host_row][host_bit] <= host_data[0];
                default: ;
            endcase
        end
    end

    // registered read: the row appears one cycle after its index
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_row];
    end

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
        (host_en && host_op == HOP_MASK) |=> (mask == $past(host_data)));

endmodule

// File: rtl/refcmp_compare.sv
module refcmp_compare
    import refcmp_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_copy,
    input  logic             in_last,
    input  logic [AW-1:0]    in_idx,
    input  logic [WIDTH-1:0] in_data,
    input  logic [AW-1:0]    win_lo,
    input  logic [AW-1:0]    win_hi,
    input  logic [WIDTH-1:0] mask,
    input  stop_mode_e       mode,
    input  logic [WIDTH-1:0] ref_row,
    output logic             diff_valid,
    output logic [AW-1:0]    diff_row,
    output logic [WIDTH-1:0] diff_bits,
    output logic             row_mism,
    output logic             fin,
    output stop_mode_e       fin_mode
);

    stage_ctl_t       s1;
    logic [AW-1:0]    s1_idx;
    logic [WIDTH-1:0] s1_data;
    logic [WIDTH-1:0] s1_mask;
    logic [WIDTH-1:0] cmp_bits;

    // stage 1: snapshot the row and its settings while the reference is read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s1_idx  <= '0;
            s1_data <= '0;
            s1_mask <= '0;
        end else begin
            s1.cmp  <= in_valid && !in_copy &&
                       row_in_window(32'(in_idx), 32'(win_lo), 32'(win_hi));
            s1.fin  <= in_valid && !in_copy && in_last;
            s1.mode <= mode;
            s1_idx  <= in_idx;
            s1_data <= in_data;
            s1_mask <= mask;
        end
    end

    assign cmp_bits = (s1_data ^ ref_row) & s1_mask;

    // stage 2: registered difference result
    always_ff @(posedge clk) begin
        if (rst) begin
            diff_valid <= 1'b0;
            diff_row   <= '0;
            diff_bits  <= '0;
            row_mism   <= 1'b0;
            fin        <= 1'b0;
            fin_mode   <= STOP_ON_EQUAL;
        end else begin
            diff_valid <= s1.cmp;
            diff_row   <= s1_idx;
            diff_bits  <= s1.cmp ? cmp_bits : '0;
            row_mism   <= s1.cmp && (|cmp_bits);
            fin        <= s1.fin;
            fin_mode   <= s1.mode;
        end
    end

    assert_diff_needs_row_R4: assert property (@(posedge clk) disable iff (rst)
        diff_valid |-> ($past(in_valid, 2) && !$past(in_copy, 2)));

    assert_masked_bits_clear_R5: assert property (@(posedge clk) disable iff (rst)
        diff_valid |-> ((diff_bits & ~$past(mask, 2)) == '0));

    assert_row_in_window_R6: assert property (@(posedge clk) disable iff (rst)
        diff_valid |-> row_in_window(32'(diff_row), 32'($past(win_lo, 2)),
                                     32'($past(win_hi, 2))));

    assert_copy_silent_R3: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_copy, 2) |-> (!diff_valid && !fin));

endmodule

// File: rtl/refcmp_verdict.sv
module refcmp_verdict
    import refcmp_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          diff_valid,
    input  logic          row_mism,
    input  logic          fin,
    input  stop_mode_e    fin_mode,
    output logic          verdict_valid,
    output logic          verdict_equal,
    output logic [CW-1:0] mismatch_count,
    output logic          stop_req
);

    logic [CW-1:0] acc;
    logic [CW-1:0] bump;
    logic [CW-1:0] total;

    // saturating row counter for the acquisition in progress
    always_comb begin
        bump  = (diff_valid && row_mism && acc != '1) ? CW'(1) : '0;
        total = acc + bump;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc            <= '0;
            verdict_valid  <= 1'b0;
            verdict_equal  <= 1'b0;
            mismatch_count <= '0;
            stop_req       <= 1'b0;
        end else if (fin) begin
            acc            <= '0;
            verdict_valid  <= 1'b1;
            verdict_equal  <= (total == '0);
            mismatch_count <= total;
            stop_req       <= stop_wanted(fin_mode, total == '0);
        end else begin
            acc           <= total;
            verdict_valid <= 1'b0;
            stop_req      <= 1'b0;
        end
    end

    assert_stop_with_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> verdict_valid);

    assert_verdict_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(fin));

    assert_count_no_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(fin) && !$past(rst)) |-> (acc >= $past(acc)));

endmodule

// File: rtl/ref_compare_top.sv
module ref_compare_top
    import refcmp_pkg::*;
#(
    parameter  int ACQ_DEPTH = 64,
    parameter  int WIDTH     = 16,
    localparam int RD        = ACQ_DEPTH / 2,
    localparam int AW        = $clog2(RD),
    localparam int BW        = $clog2(WIDTH),
    localparam int CW        = $clog2(RD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_en,
    input  logic [1:0]       host_op,
    input  logic [AW-1:0]    host_row,
    input  logic [BW-1:0]    host_bit,
    input  logic [WIDTH-1:0] host_data,
    input  logic             copy_en,
    input  logic             stop_mode,
    input  logic [AW-1:0]    win_lo,
    input  logic [AW-1:0]    win_hi,
    input  logic             row_valid,
    input  logic             row_last,
    input  logic [AW-1:0]    row_idx,
    input  logic [WIDTH-1:0] row_data,
    output logic             diff_valid,
    output logic [AW-1:0]    diff_row,
    output logic [WIDTH-1:0] diff_bits,
    output logic             row_mismatch,
    output logic             verdict_valid,
    output logic             verdict_equal,
    output logic [CW-1:0]    mismatch_count,
    output logic             stop_req
);

    logic [WIDTH-1:0] ref_row;
    logic [WIDTH-1:0] mask;
    logic             fin;
    stop_mode_e       fin_mode;

    refcmp_image #(.WIDTH(WIDTH), .ROWS(RD)) u_image (
        .clk      (clk),
        .rst      (rst),
        .host_en  (host_en),
        .host_op  (host_op_e'(host_op)),
        .host_row (host_row),
        .host_bit (host_bit),
        .host_data(host_data),
        .cp_en    (row_valid && copy_en),
        .cp_row   (row_idx),
        .cp_data  (row_data),
        .rd_row   (row_idx),
        .rd_data  (ref_row),
        .mask     (mask)
    );

    refcmp_compare #(.WIDTH(WIDTH), .AW(AW)) u_compare (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (row_valid),
        .in_copy   (copy_en),
        .in_last   (row_last),
        .in_idx    (row_idx),
        .in_data   (row_data),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .mask      (mask),
        .mode      (stop_mode_e'(stop_mode)),
        .ref_row   (ref_row),
        .diff_valid(diff_valid),
        .diff_row  (diff_row),
        .diff_bits (diff_bits),
        .row_mism  (row_mismatch),
        .fin       (fin),
        .fin_mode  (fin_mode)
    );

    refcmp_verdict #(.CW(CW)) u_verdict (
        .clk           (clk),
        .rst           (rst),
        .diff_valid    (diff_valid),
        .row_mism      (row_mismatch),
        .fin           (fin),
        .fin_mode      (fin_mode),
        .verdict_valid (verdict_valid),
        .verdict_equal (verdict_equal),
        .mismatch_count(mismatch_count),
        .stop_req      (stop_req)
    );

    assert_mismatch_flag_R7: assert property (@(posedge clk) disable iff (rst)
        row_mismatch |-> (diff_valid && diff_bits != '0));

endmodule

// File: tb/ref_compare_top_tb.sv
module ref_compare_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RD = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_en = 1'b0;
    logic [1:0]  host_op = 2'd3;
    logic [4:0]  host_row = '0;
    logic [3:0]  host_bit = '0;
    logic [15:0] host_data = '0;
    logic        copy_en = 1'b0;
    logic        stop_mode = 1'b0;
    logic [4:0]  win_lo = '0;
    logic [4:0]  win_hi = 5'd31;
    logic        row_valid = 1'b0;
    logic        row_last = 1'b0;
    logic [4:0]  row_idx = '0;
    logic [15:0] row_data = '0;
    logic        diff_valid, row_mismatch, verdict_valid, verdict_equal, stop_req;
    logic [4:0]  diff_row;
    logic [15:0] diff_bits;
    logic [5:0]  mismatch_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_compare_top u_dut (
        .clk(clk), .rst(rst), .host_en(host_en), .host_op(host_op),
        .host_row(host_row), .host_bit(host_bit), .host_data(host_data),
        .copy_en(copy_en), .stop_mode(stop_mode), .win_lo(win_lo), .win_hi(win_hi),
        .row_valid(row_valid), .row_last(row_last), .row_idx(row_idx),
        .row_data(row_data), .diff_valid(diff_valid), .diff_row(diff_row),
        .diff_bits(diff_bits), .row_mismatch(row_mismatch),
        .verdict_valid(verdict_valid), .verdict_equal(verdict_equal),
        .mismatch_count(mismatch_count), .stop_req(stop_req)
    );

    typedef struct {
        bit          v;
        logic [4:0]  row;
        logic [15:0] bits;
        bit          mism;
    } dexp_t;

    typedef struct {
        bit v;
        bit eq;
        int cnt;
        bit stop;
    } vexp_t;

    logic [15:0] m_mem [RD];
    logic [15:0] m_mask = 16'hffff;
    logic [15:0] dbuf [RD];
    int          acc = 0;
    dexp_t       dq [2];
    vexp_t       vq [3];
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;
    string       cur_tag = "R1";

    task automatic report(input bit ok, input string tag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic bit in_win(input logic [4:0] i);
        return (i >= win_lo) && (i <= win_hi);
    endfunction

    // one clock: compute what the currently driven inputs should produce, then check
    task automatic tick();
        dexp_t nd;
        vexp_t nv;
        nd = '{v: 1'b0, row: '0, bits: '0, mism: 1'b0};
        nv = '{v: 1'b0, eq: 1'b0, cnt: 0, stop: 1'b0};
        if (row_valid && !copy_en) begin
            if (in_win(row_idx)) begin
                nd.v = 1'b1;
                nd.row = row_idx;
                nd.bits = (row_data ^ m_mem[row_idx]) & m_mask;
                nd.mism = (nd.bits != 0);
            end
            if (row_last) begin
                nv.v = 1'b1;
                nv.cnt = acc + int'(nd.mism);
                nv.eq = (nv.cnt == 0);
                nv.stop = stop_mode ? !nv.eq : nv.eq;
                acc = 0;
            end else begin
                acc += int'(nd.mism);
            end
        end
        if (row_valid && copy_en) m_mem[row_idx] = row_data;
        if (host_en) begin
            case (host_op)
                2'd0: m_mem[host_row] = host_data;
                2'd1: m_mem[host_row][host_bit] = host_data[0];
                2'd2: m_mask = host_data;
                default: ;
            endcase
        end
        dq[1] = dq[0]; dq[0] = nd;
        vq[2] = vq[1]; vq[1] = vq[0]; vq[0] = nv;
        @(posedge clk);
        @(negedge clk);
        report(diff_valid == dq[1].v &&
               (!dq[1].v || (diff_row == dq[1].row && diff_bits == dq[1].bits)),
               cur_tag, $sformatf("diff act v=%0b row=%0d bits=%h exp v=%0b row=%0d bits=%h",
                   diff_valid, diff_row, diff_bits, dq[1].v, dq[1].row, dq[1].bits));
        report(row_mismatch == (dq[1].v && dq[1].mism), "R7",
               $sformatf("row_mismatch act=%0b exp=%0b", row_mismatch, dq[1].v && dq[1].mism));
        report(verdict_valid == vq[2].v &&
               (!vq[2].v || (verdict_equal == vq[2].eq && int'(mismatch_count) == vq[2].cnt)),
               {"R8 ", cur_tag}, $sformatf("verdict act v=%0b eq=%0b cnt=%0d exp v=%0b eq=%0b cnt=%0d",
                   verdict_valid, verdict_equal, mismatch_count, vq[2].v, vq[2].eq, vq[2].cnt));
        report(stop_req == (vq[2].v && vq[2].stop), "R9",
               $sformatf("stop_req act=%0b exp=%0b", stop_req, vq[2].v && vq[2].stop));
    endtask

    task automatic host(input logic [1:0] op, input logic [4:0] r,
                        input logic [3:0] b, input logic [15:0] d);
        host_en = 1'b1; host_op = op; host_row = r; host_bit = b; host_data = d;
        tick();
        host_en = 1'b0; host_op = 2'd3;
    endtask

    // stream a full acquisition of RD rows from dbuf, then let the pipeline drain
    task automatic acquire(input bit copy);
        copy_en = copy;
        for (int i = 0; i < RD; i++) begin
            row_valid = 1'b1;
            row_idx = 5'(i);
            row_data = dbuf[i];
            row_last = (i == RD - 1);
            tick();
        end
        row_valid = 1'b0; row_last = 1'b0; copy_en = 1'b0;
        repeat (3) tick();
    endtask

    task automatic fill_random();
        for (int i = 0; i < RD; i++) dbuf[i] = 16'($urandom);
    endtask

    task automatic fill_from_ref(input int flip_odds);
        for (int i = 0; i < RD; i++)
            dbuf[i] = m_mem[i] ^ ((($urandom % flip_odds) == 0) ? 16'($urandom) : 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0de5));
        for (int i = 0; i < 2; i++) dq[i] = '{v: 1'b0, row: '0, bits: '0, mism: 1'b0};
        for (int i = 0; i < 3; i++) vq[i] = '{v: 1'b0, eq: 1'b0, cnt: 0, stop: 1'b0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        report(diff_valid == 0 && diff_bits == 0 && row_mismatch == 0 && verdict_valid == 0 &&
               verdict_equal == 0 && mismatch_count == 0 && stop_req == 0, "R1",
               $sformatf("reset outputs act=%0b%0b%0b%0b%0b cnt=%0d exp=all zero",
                   diff_valid, row_mismatch, verdict_valid, verdict_equal, stop_req, mismatch_count));
        rst = 1'b0;
        tick();

        // R2: full row writes, then identical data gives an equal verdict
        cur_tag = "R2";
        fill_random();
        for (int i = 0; i < RD; i++) host(2'd0, 5'(i), 4'd0, dbuf[i]);
        acquire(1'b0);

        // R1: mask out of reset enables every channel, so every flip shows
        cur_tag = "R1";
        for (int i = 0; i < RD; i++) dbuf[i] = m_mem[i] ^ 16'hffff;
        acquire(1'b0);

        // R2: single-bit edit on row 7, compare against pre-edit data
        cur_tag = "R2";
        for (int i = 0; i < RD; i++) dbuf[i] = m_mem[i];
        host(2'd1, 5'd7, 4'd11, {15'd0, ~m_mem[7][11]});
        host(2'd3, 5'd7, 4'd0, 16'hffff);
        acquire(1'b0);

        // R5: partial mask hides changed bits
        cur_tag = "R5";
        host(2'd2, 5'd0, 4'd0, 16'h0f3c);
        fill_random();
        acquire(1'b0);
        host(2'd2, 5'd0, 4'd0, 16'hffff);

        // R6: window in the middle, then a single-row window at the last row
        cur_tag = "R6";
        win_lo = 5'd5; win_hi = 5'd20;
        fill_random();
        acquire(1'b0);
        win_lo = 5'd31; win_hi = 5'd31;
        fill_random();
        acquire(1'b0);

        // R10: inverted window compares nothing
        cur_tag = "R10";
        win_lo = 5'd20; win_hi = 5'd4;
        fill_random();
        acquire(1'b0);
        win_lo = 5'd0; win_hi = 5'd31;

        // R3: copy an acquisition, then the same data compares equal
        cur_tag = "R3";
        fill_random();
        acquire(1'b1);
        acquire(1'b0);

        // R9: stop on unequal, with unequal and then equal data
        cur_tag = "R9";
        stop_mode = 1'b1;
        fill_from_ref(2);
        acquire(1'b0);
        fill_from_ref(1000000);
        acquire(1'b0);
        stop_mode = 1'b0;

        // R4: random settings, masks, edits and sparse flips
        cur_tag = "R4";
        for (int it = 0; it < 8; it++) begin
            logic [4:0] a, b;
            a = 5'($urandom); b = 5'($urandom);
            win_lo = (a < b) ? a : b;
            win_hi = (a < b) ? b : a;
            stop_mode = 1'($urandom);
            host(2'd2, 5'd0, 4'd0, 16'($urandom) | 16'h0101);
            host(2'd1, 5'($urandom), 4'($urandom), 16'($urandom));
            fill_from_ref(3);
            acquire(1'b0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule